// File: doc/BRIEF.md
# Flash page write-protection controller

This block sits between a flash programming path and the rest of the chip. It keeps per-bank protection state and filters every page write request against it. There are two banks. Bank 0 holds 60 pages of 512 bytes. Bank 1 holds 128 pages. Each bank owns a 32-bit working protection word that decides which pages may be written. Bit 31 of that word also says whether the debug port may read the bank. A bit that is cleared blocks, and a bit that is set allows.

Each bank also has a persistent lock word with the same bit layout. Only the power-on reset clears it. Every system reset reloads the working word from the lock word, so a setting can be tried in the working word and then committed to the lock word to make it stick. A lock word of zero means no lock is programmed, and the working word then comes out of reset as all ones. Software reaches all four words through a small register port. Write requests carry a bank, a page number and data. An accepted request reaches the flash side one cycle later. A rejected one produces a one-cycle error pulse instead.

Top module: `flash_wprot`

## Requirements
- R1: After power-on reset both lock words read 0 and both working words read 0xFFFFFFFF.
- R2: A system reset alone leaves the lock words unchanged. It loads each working word from its lock word, or with 0xFFFFFFFF when that lock word is 0.
- R3: Register address bit 0 selects working (0) or lock (1), and address bit 1 selects the bank. A written value reads back at the same address on the next cycle.
- R4: In bank 0, page p < 58 is governed by bit p/2, page 58 by bit 29 and page 59 by bit 30.
- R5: In bank 1, page p < 120 is governed by bit p/4, and pages 120 to 127 all by bit 30.
- R6: A request whose governing bit is 1 raises `fl_wr_o` one cycle later, with the request's bank, page and data on the flash outputs, and `err_o` stays low.
- R7: A request whose governing bit is 0 raises `err_o` for one cycle, one cycle later, and `fl_wr_o` stays low.
- R8: A bank 0 request for a page above 59 is rejected as in R7 whatever the protection word holds.
- R9: `dbg_rd_ok_o[b]` equals bit 31 of bank b's working word.
- R10: A cycle without a request is followed by a cycle with both `fl_wr_o` and `err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, asynchronous, active low; reloads working words |
| por_ni | input | 1 | Power-on reset, asynchronous, active low; clears lock words |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | {bank, select}: select 0 = working, 1 = lock |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| wr_req_i | input | 1 | Page write request |
| wr_bank_i | input | 1 | Requested bank |
| wr_page_i | input | 7 | Requested 512-byte page |
| wr_data_i | input | 32 | Request data |
| fl_wr_o | output | 1 | Accepted write toward flash |
| fl_bank_o | output | 1 | Bank of the accepted write |
| fl_page_o | output | 7 | Page of the accepted write |
| fl_data_o | output | 32 | Data of the accepted write |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| dbg_rd_ok_o | output | 2 | Per-bank debug read permission |

## Verification
The bench concentrates on the seams of the page map: pages 56 to 60 in bank 0 and 116 to 127 in bank 1. A uniform two- or four-page divider would put page 59 on bit 29, or page 124 on bit 31, and the bench would see the wrong accept or reject there. Out-of-range bank 0 pages are sent with every bit set, to catch a design that only decodes the word. Resets are exercised with both zero and non-zero lock words. This catches a reload that ignores the lock, or one that treats an unprogrammed lock as "protect everything", and it also confirms that a system reset leaves the lock words intact.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned PAGE_W  = 7;
  localparam int unsigned NUM_BNK = 2;
  localparam int unsigned BANK_W  = $clog2(NUM_BNK);
  localparam int unsigned ADDR_W  = BANK_W + 1;
  localparam int unsigned BIT_W   = $clog2(REG_W);
  localparam int unsigned DBG_BIT = REG_W - 1;

  // per-bank page map: pages below FINE_END use bit page>>FINE_SH,
  // the tail uses FINE_END>>FINE_SH + ((page-FINE_END)>>TAIL_SH)
  localparam int unsigned FINE_SH  [NUM_BNK] = '{1, 2};
  localparam int unsigned FINE_END [NUM_BNK] = '{58, 120};
  localparam int unsigned TAIL_SH  [NUM_BNK] = '{0, 3};
  localparam int unsigned NUM_PG   [NUM_BNK] = '{60, 128};

  typedef logic [REG_W-1:0] prot_word_t;
endpackage

// File: rtl/fwp_regs.sv
module fwp_regs
  import fwp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  prot_word_t        reg_wdata_i,
  output prot_word_t        reg_rdata_o,
  output prot_word_t        work_o [NUM_BNK]
);
  prot_word_t lock_q [NUM_BNK];
  prot_word_t work_q [NUM_BNK];

  for (genvar b = 0; b < NUM_BNK; b++) begin : g_bank
    logic hit_lock, hit_work;
    assign hit_lock = reg_we_i && reg_addr_i[0] && (reg_addr_i[ADDR_W-1:1] == BANK_W'(b));
    assign hit_work = reg_we_i && !reg_addr_i[0] && (reg_addr_i[ADDR_W-1:1] == BANK_W'(b));

    // survives system reset
    always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)       lock_q[b] <= '0;
      else if (hit_lock) lock_q[b] <= reg_wdata_i;
    end

    // zero lock word = not programmed -> open
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       work_q[b] <= (lock_q[b] == '0) ? '1 : lock_q[b];
      else if (hit_work) work_q[b] <= reg_wdata_i;
    end

    assign work_o[b] = work_q[b];
  end

  always_comb begin
    if (reg_addr_i[0]) reg_rdata_o = lock_q[reg_addr_i[ADDR_W-1:1]];
    else               reg_rdata_o = work_q[reg_addr_i[ADDR_W-1:1]];
  end
endmodule

// File: rtl/fwp_page_map.sv
module fwp_page_map
  import fwp_pkg::*;
#(
  parameter int unsigned FINE_SHIFT = 1,
  parameter int unsigned FINE_LIMIT = 58,
  parameter int unsigned TAIL_SHIFT = 0,
  parameter int unsigned PAGE_COUNT = 60
) (
  input  logic [PAGE_W-1:0] page_i,
  output logic [BIT_W-1:0]  bit_o,
  output logic              valid_o
);
  localparam int unsigned CW        = PAGE_W + 1;
  localparam logic [CW-1:0] FINE_C  = CW'(FINE_LIMIT);
  localparam logic [CW-1:0] COUNT_C = CW'(PAGE_COUNT);
  localparam logic [CW-1:0] TAIL_B  = CW'(FINE_LIMIT >> FINE_SHIFT);

  logic [CW-1:0] pg, idx;

  always_comb begin
    pg = {1'b0, page_i};
    if (pg < FINE_C) idx = pg >> FINE_SHIFT;
    else             idx = TAIL_B + ((pg - FINE_C) >> TAIL_SHIFT);
    valid_o = (pg < COUNT_C) && (idx < CW'(DBG_BIT));
    bit_o   = idx[BIT_W-1:0];
  end
endmodule

// File: rtl/fwp_gate.sv
module fwp_gate
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              allow_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              fl_wr_o,
  output logic [BANK_W-1:0] fl_bank_o,
  output logic [PAGE_W-1:0] fl_page_o,
  output logic [DATA_W-1:0] fl_data_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_wr_o   <= 1'b0;
      err_o     <= 1'b0;
      fl_bank_o <= '0;
      fl_page_o <= '0;
      fl_data_o <= '0;
    end else begin
      fl_wr_o <= req_i && allow_i;
      err_o   <= req_i && !allow_i;
      if (req_i && allow_i) begin
        fl_bank_o <= bank_i;
        fl_page_o <= page_i;
        fl_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/flash_wprot.sv
module flash_wprot
  import fwp_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              wr_req_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              fl_wr_o,
  output logic [BANK_W-1:0] fl_bank_o,
  output logic [PAGE_W-1:0] fl_page_o,
  output logic [DATA_W-1:0] fl_data_o,
  output logic              err_o,
  output logic [NUM_BNK-1:0] dbg_rd_ok_o
);
  prot_word_t             work [NUM_BNK];
  logic [NUM_BNK-1:0]     allow_b;
  logic                   allow;

  fwp_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .por_ni      (por_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .work_o      (work)
  );

  for (genvar b = 0; b < NUM_BNK; b++) begin : g_map
    logic [BIT_W-1:0] bit_idx;
    logic             valid;
    fwp_page_map #(
      .FINE_SHIFT (FINE_SH[b]),
      .FINE_LIMIT (FINE_END[b]),
      .TAIL_SHIFT (TAIL_SH[b]),
      .PAGE_COUNT (NUM_PG[b])
    ) u_map (
      .page_i  (wr_page_i),
      .bit_o   (bit_idx),
      .valid_o (valid)
    );
    assign allow_b[b]     = valid && work[b][bit_idx];
    assign dbg_rd_ok_o[b] = work[b][DBG_BIT];
  end

  assign allow = allow_b[wr_bank_i];

  fwp_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (wr_req_i),
    .allow_i   (allow),
    .bank_i    (wr_bank_i),
    .page_i    (wr_page_i),
    .data_i    (wr_data_i),
    .fl_wr_o   (fl_wr_o),
    .fl_bank_o (fl_bank_o),
    .fl_page_o (fl_page_o),
    .fl_data_o (fl_data_o),
    .err_o     (err_o)
  );
endmodule

// File: rtl/fwp_chk.sv
module fwp_chk
  import fwp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              wr_req_i,
  input logic [BANK_W-1:0] wr_bank_i,
  input logic [PAGE_W-1:0] wr_page_i,
  input logic              fl_wr_o,
  input logic              err_o,
  input logic [NUM_BNK-1:0] dbg_rd_ok_o
);
  // R3
  reg_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    reg_we_i ##1 (reg_addr_i == $past(reg_addr_i)) |-> reg_rdata_o == $past(reg_wdata_i));

  // R6
  req_answered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    wr_req_i |=> (fl_wr_o || err_o));

  // R7
  excl_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $onehot0({fl_wr_o, err_o}));

  // R8
  b0_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_req_i && wr_bank_i == '0 && wr_page_i >= PAGE_W'(NUM_PG[0])) |=> err_o);

  // R9
  dbg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (reg_we_i && !reg_addr_i[0]) |=>
      dbg_rd_ok_o[$past(reg_addr_i[ADDR_W-1:1])] == $past(reg_wdata_i[DBG_BIT]));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !wr_req_i |=> !(fl_wr_o || err_o));
endmodule

bind flash_wprot fwp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ni      (por_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .wr_req_i    (wr_req_i),
  .wr_bank_i   (wr_bank_i),
  .wr_page_i   (wr_page_i),
  .fl_wr_o     (fl_wr_o),
  .err_o       (err_o),
  .dbg_rd_ok_o (dbg_rd_ok_o)
);

// File: tb/flash_wprot_test.sv
`timescale 1ns/1ps
module flash_wprot_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        wr_req_i = 1'b0;
  logic [0:0]  wr_bank_i = '0;
  logic [6:0]  wr_page_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        fl_wr_o, err_o;
  logic [0:0]  fl_bank_o;
  logic [6:0]  fl_page_o;
  logic [31:0] fl_data_o;
  logic [1:0]  dbg_rd_ok_o;

  int total = 0, bad = 0;
  bit [31:0] work_m [2];
  bit [31:0] lock_m [2];

  always #2.5 clk = ~clk;

  flash_wprot uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .wr_req_i(wr_req_i), .wr_bank_i(wr_bank_i), .wr_page_i(wr_page_i), .wr_data_i(wr_data_i),
    .fl_wr_o(fl_wr_o), .fl_bank_o(fl_bank_o), .fl_page_o(fl_page_o), .fl_data_o(fl_data_o),
    .err_o(err_o), .dbg_rd_ok_o(dbg_rd_ok_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // governing bit, -1 when page is outside the bank
  function automatic int gov_bit(bit b, int p);
    if (!b) return (p < 58) ? p / 2 : (p < 60) ? 29 + (p - 58) : -1;
    return (p < 120) ? p / 4 : 30;
  endfunction

  task automatic do_reset(bit por);
    @(negedge clk);
    rst_ni = 1'b0;
    if (por) por_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1; por_ni = 1'b1;
    for (int b = 0; b < 2; b++) begin
      if (por) lock_m[b] = '0;
      work_m[b] = (lock_m[b] == 0) ? 32'hFFFF_FFFF : lock_m[b];
    end
  endtask

  task automatic reg_wr(bit b, bit lk, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = {b, lk}; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
    if (lk) lock_m[b] = d; else work_m[b] = d;
  endtask

  task automatic reg_chk(string tag);
    for (int a = 0; a < 4; a++) begin
      reg_addr_i = 2'(a);
      #0.5;
      chk(tag, reg_rdata_o, a[0] ? lock_m[a / 2] : work_m[a / 2]);
    end
    chk({tag, " R9 dbg"}, dbg_rd_ok_o, {work_m[1][31], work_m[0][31]});
  endtask

  task automatic req(string tag, bit b, int p);
    int bi = gov_bit(b, p);
    bit ok = (bi >= 0) && work_m[b][bi];
    logic [31:0] d = $urandom;
    @(negedge clk);
    wr_req_i = 1'b1; wr_bank_i = b; wr_page_i = 7'(p); wr_data_i = d;
    @(negedge clk);
    wr_req_i = 1'b0;
    chk($sformatf("%s b%0d p%0d outcome", tag, b, p), {fl_wr_o, err_o}, {ok, !ok});
    if (ok) chk($sformatf("%s R6 payload", tag), {fl_bank_o, fl_page_o, fl_data_o}, {b, 7'(p), d});
    @(negedge clk);
    chk($sformatf("%s R10 quiet", tag), {fl_wr_o, err_o}, 2'b00);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #7;
    do_reset(1'b1);
    reg_chk("R1 por");

    // bank 0 seams, all open
    for (int p = 56; p < 62; p++) req(p >= 60 ? "R8" : "R4", 1'b0, p);
    req("R8", 1'b0, 127);

    reg_wr(1'b0, 1'b0, 32'hDFFF_FFFF & ~32'h1000_0000); // clear bit 29, 28
    reg_chk("R3 b0");
    for (int p = 55; p < 60; p++) req("R4", 1'b0, p);
    reg_wr(1'b0, 1'b0, 32'hBFFF_FFFE); // clear 30 and 0
    for (int p = 0; p < 3; p++) req("R4", 1'b0, p);
    req("R4", 1'b0, 58); req("R4", 1'b0, 59);

    reg_wr(1'b1, 1'b0, 32'h9FFF_FFFF); // clear 30, 29
    for (int p = 114; p < 128; p++) req("R5", 1'b1, p);
    reg_wr(1'b1, 1'b0, 32'h7FFF_FFFE);
    reg_chk("R9 b1");
    for (int p = 0; p < 5; p++) req("R5", 1'b1, p);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k < 2) reg_wr(1'($urandom), 1'b0, $urandom);
      else if (k == 2) begin reg_wr(1'($urandom), 1'b1, $urandom); reg_chk("R3 rnd"); end
      else begin
        bit b = 1'($urandom);
        req(b ? "R5/R7" : "R4/R7", b, $urandom_range(0, 127));
      end
    end

    // lock commit and system reset
    reg_wr(1'b0, 1'b1, 32'h7FFF_0F0F);
    reg_wr(1'b1, 1'b1, 32'h0);
    reg_wr(1'b1, 1'b0, 32'h1234_5678);
    do_reset(1'b0);
    reg_chk("R2 sysrst");
    req("R2", 1'b0, 8); req("R2", 1'b0, 10); req("R2", 1'b1, 127);
    reg_wr(1'b1, 1'b1, 32'h8000_0001);
    do_reset(1'b0);
    reg_chk("R2 sysrst2");
    req("R2", 1'b1, 3); req("R2", 1'b1, 4);

    do_reset(1'b1);
    reg_chk("R1 por2");
    req("R6", 1'b1, 100);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule